// File: doc/BRIEF.md
# Byte-Queued JTAG Bit Engine

This block drives a JTAG chain from a host. Software loads mode-select bytes and data-in bytes into two separate queues through a small register bus. The engine does not clock anything until it receives a start command. It then takes one mode-select byte and one data-in byte together and sends their eight bit pairs out on the test pins, least significant bit first. At each rising test clock edge it captures the test-data-out pin and packs the captured bits into bytes for a third queue, which the host reads back.

When no complete byte pair is waiting, a started engine keeps toggling the test clock and holds the pins at the last bit it sent. Every transfer set therefore has to leave the chain in a stable TAP pause state. The packer keeps each finished capture byte until the next byte completes. The last byte of a set only reaches the read queue after the host sends one more byte pair to push it out. The host polls a busy flag, sends a stop command when the set has drained, and can send a clear command that puts the engine back to its reset state.

Register offsets on the 3-bit address: 0 queues a data-in byte, 1 queues a mode-select byte, 2 takes a command byte, 3 returns status, 4 reads and pops a captured byte.

Top module: `jtg_byte_engine`

## Requirements
- R1: After reset, tck_o, tms_o and tdi_o are 0 (the idle levels set by parameter) and a status read at address 3 returns 0.
- R2: A write to address 0 queues a data-in byte and a write to address 1 queues a mode-select byte. A byte written while its queue already holds FIFO_DEPTH bytes is dropped and is never shifted.
- R3: No tck_o edge occurs before command byte 0x00 (start) is written to address 2.
- R4: Each byte pair is shifted as eight bit pairs, bit 0 first. tms_o and tdi_o change only while tck_o is low. A byte is shifted only when both queues hold one, and both are removed together.
- R5: While started, once the last pair has been shifted, tck_o keeps toggling and tms_o and tdi_o hold bit 7 of the last pair.
- R6: tdo_i is sampled at each rising tck_o of a data bit and packed bit 0 first. A packed byte enters the read queue only when the following byte finishes shifting. A read at address 4 returns the oldest byte and removes it.
- R7: Command byte 0x01 (stop) drives tck_o low within two clocks and holds it low.
- R8: While started, each high phase and each idle low phase of tck_o lasts HALF_DIV clocks.
- R9: Command byte 0x02 (clear) empties all three queues, discards the byte held in the packer, stops the engine and returns tms_o and tdi_o to their idle levels.
- R10: Status at address 3 has bit 0 set while a byte is shifting or a complete byte pair is waiting, and bit 1 set while the read queue is not empty. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe; pops the read queue at offset 4 |
| bus_rdata | output | 8 | Read data, valid in the same clock as bus_rd |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Test data to the chain |
| tdo_i | input | 1 | Test data from the chain |

## Verification
A fault in the bit index or in the shift registers shows up on tms_o and tdi_o within the first byte. The bench reassembles each byte from the values present at every rising tck_o. A packer that releases a byte too early or too late changes the status bit 1 seen right after a set has drained, so the fault is visible within one byte time. A fault in the pacing counter or in the run flag changes the high-phase length or the stop behaviour within one tck_o period. A faulty queue full or clear path lets a dropped or discarded byte reach tms_o as a 1 that the bench never expects.

// File: rtl/jtg_pkg.sv
package jtg_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_TDI  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_TMS  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMD  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_TDO  = 3'd4;

    typedef enum logic [7:0] {
        CMD_GO    = 8'h00,
        CMD_STOP  = 8'h01,
        CMD_CLEAR = 8'h02
    } cmd_e;

    typedef struct packed {
        logic [7:0] tms;
        logic [7:0] tdi;
    } bit_pair_t;

    typedef struct packed {
        logic [5:0] spare;
        logic       tdo_avail;
        logic       busy;
    } stat_t;

    function automatic stat_t make_status(input logic busy, input logic tdo_avail);
        stat_t s;
        s.spare     = '0;
        s.tdo_avail = tdo_avail;
        s.busy      = busy;
        return s;
    endfunction

endpackage

// File: rtl/jtg_fifo.sv
module jtg_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem [DEPTH];
    logic [AW-1:0]   wp_q, rp_q;
    logic [CNTW-1:0] cnt_q;
    logic            do_push, do_pop;

    assign full_o  = (cnt_q == CNTW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign dout_o  = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din_i;
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CNTW'(1);
                2'b01:   cnt_q <= cnt_q - CNTW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o && !pop_i && !flush_i) |=> (cnt_q == $past(cnt_q))) // R2
        else $error("queue grew while full");

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (pop_i && empty_o && !push_i && !flush_i) |=> empty_o) // R6
        else $error("queue popped while empty");

endmodule

// File: rtl/jtg_regif.sv
module jtg_regif
    import jtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  stat_t             status_i,
    input  logic [7:0]        tdo_head_i,
    output logic              tdi_push_o,
    output logic              tms_push_o,
    output logic              tdo_pop_o,
    output logic              clear_o,
    output logic              run_o,
    output logic [7:0]        rdata_o
);
    logic cmd_wr;
    logic run_q;

    assign cmd_wr     = wr_i && (addr_i == ADDR_CMD);
    assign tdi_push_o = wr_i && (addr_i == ADDR_TDI);
    assign tms_push_o = wr_i && (addr_i == ADDR_TMS);
    assign tdo_pop_o  = rd_i && (addr_i == ADDR_TDO);
    assign clear_o    = cmd_wr && (wdata_i == CMD_CLEAR);
    assign run_o      = run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else if (cmd_wr) begin
            if (wdata_i == CMD_GO)
                run_q <= 1'b1;
            else if (wdata_i == CMD_STOP || wdata_i == CMD_CLEAR)
                run_q <= 1'b0;
        end
    end

    always_comb begin
        case (addr_i)
            ADDR_STAT: rdata_o = status_i;
            ADDR_TDO:  rdata_o = status_i.tdo_avail ? tdo_head_i : 8'h00;
            default:   rdata_o = 8'h00;
        endcase
    end

    AST_GO_SETS_RUN: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == ADDR_CMD && wdata_i == CMD_GO) |=> run_o) // R3
        else $error("start command ignored");

    AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == ADDR_CMD && wdata_i != CMD_GO && wdata_i <= CMD_CLEAR) |=> !run_o) // R7
        else $error("stop or clear left engine running");

endmodule

// File: rtl/jtg_shifter.sv
module jtg_shifter
    import jtg_pkg::*;
#(
    parameter int   HALF_DIV = 2,
    parameter logic IDLE_TMS = 1'b0,
    parameter logic IDLE_TDI = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run_i,
    input  logic      flush_i,
    input  logic      pair_avail_i,
    input  bit_pair_t pair_i,
    input  logic      tdo_full_i,
    input  logic      tdo_i,
    output logic      pair_pop_o,
    output logic      tdo_push_o,
    output logic [7:0] tdo_byte_o,
    output logic      active_o,
    output logic      tck_o,
    output logic      tms_o,
    output logic      tdi_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] div_q;
    logic          tck_q, tms_q, tdi_q, active_q;
    logic [2:0]    idx_q;
    bit_pair_t     sh_q;
    logic [7:0]    cap_q, hold_q;
    logic          hold_v_q;
    logic          edge_now, can_load, done;

    assign edge_now   = (div_q == CW'(HALF_DIV - 1));
    assign can_load   = run_i && !active_q && !tck_q && pair_avail_i && !tdo_full_i;
    assign done       = run_i && edge_now && tck_q && active_q && (idx_q == 3'd7);
    assign pair_pop_o = can_load && !flush_i;
    assign tdo_push_o = done && hold_v_q && !flush_i;
    assign tdo_byte_o = hold_q;
    assign active_o   = active_q;
    assign tck_o      = tck_q;
    assign tms_o      = tms_q;
    assign tdi_o      = tdi_q;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            div_q    <= '0;
            tck_q    <= 1'b0;
            tms_q    <= IDLE_TMS;
            tdi_q    <= IDLE_TDI;
            active_q <= 1'b0;
            idx_q    <= '0;
            sh_q     <= '0;
            cap_q    <= '0;
            hold_q   <= '0;
            hold_v_q <= 1'b0;
        end else if (!run_i) begin
            tck_q <= 1'b0;
            div_q <= '0;
        end else if (can_load) begin
            sh_q     <= pair_i;
            tms_q    <= pair_i.tms[0];
            tdi_q    <= pair_i.tdi[0];
            idx_q    <= '0;
            active_q <= 1'b1;
            div_q    <= '0;
        end else if (edge_now) begin
            div_q <= '0;
            tck_q <= !tck_q;
            if (!tck_q) begin
                if (active_q) cap_q[idx_q] <= tdo_i;
            end else if (active_q) begin
                if (idx_q == 3'd7) begin
                    active_q <= 1'b0;
                    hold_q   <= cap_q;
                    hold_v_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 3'd1;
                    tms_q <= sh_q.tms[idx_q + 3'd1];
                    tdi_q <= sh_q.tdi[idx_q + 3'd1];
                end
            end
        end else begin
            div_q <= div_q + CW'(1);
        end
    end

    AST_TCK_HELD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !tck_q) // R7
        else $error("tck moved while stopped");

    AST_PINS_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        tck_q |=> (!tck_q || ($stable(tms_q) && $stable(tdi_q)))) // R4
        else $error("tms/tdi changed while tck high");

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !flush_i) |=> (active_q || ($stable(tms_q) && $stable(tdi_q)))) // R5
        else $error("pins changed while idle");

    AST_NO_TDO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        tdo_push_o |-> !tdo_full_i) // R6
        else $error("packed byte pushed into full queue");

    AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
        ((tck_q != $past(tck_q)) && $past(run_i) && !$past(flush_i)) |-> ($past(div_q) == CW'(HALF_DIV - 1))) // R8
        else $error("tck toggled before half period elapsed");

endmodule

// File: rtl/jtg_byte_engine.sv
module jtg_byte_engine
    import jtg_pkg::*;
#(
    parameter int   FIFO_DEPTH = 16,
    parameter int   HALF_DIV   = 2,
    parameter logic IDLE_TMS   = 1'b0,
    parameter logic IDLE_TDI   = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_wr,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata,
    output logic       tck_o,
    output logic       tms_o,
    output logic       tdi_o,
    input  logic       tdo_i
);
    logic       tdi_push, tms_push, tdo_pop, clear, run;
    logic       tdi_empty, tdi_full, tms_empty, tms_full, tdo_empty, tdo_full;
    logic       pair_pop, pair_avail, tdo_push, active;
    logic [7:0] tdi_head, tms_head, tdo_head, tdo_byte;
    bit_pair_t  pair;
    stat_t      status;

    assign pair_avail = !tdi_empty && !tms_empty;
    assign pair.tms   = tms_head;
    assign pair.tdi   = tdi_head;
    assign status     = make_status(active || pair_avail, !tdo_empty);

    jtg_regif u_regif (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .wr_i       (bus_wr),
        .rd_i       (bus_rd),
        .status_i   (status),
        .tdo_head_i (tdo_head),
        .tdi_push_o (tdi_push),
        .tms_push_o (tms_push),
        .tdo_pop_o  (tdo_pop),
        .clear_o    (clear),
        .run_o      (run),
        .rdata_o    (bus_rdata)
    );

    jtg_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_tdi_q (
        .clk(clk), .rst(rst), .flush_i(clear),
        .push_i(tdi_push), .din_i(bus_wdata), .pop_i(pair_pop),
        .dout_o(tdi_head), .empty_o(tdi_empty), .full_o(tdi_full)
    );

    jtg_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_tms_q (
        .clk(clk), .rst(rst), .flush_i(clear),
        .push_i(tms_push), .din_i(bus_wdata), .pop_i(pair_pop),
        .dout_o(tms_head), .empty_o(tms_empty), .full_o(tms_full)
    );

    jtg_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_tdo_q (
        .clk(clk), .rst(rst), .flush_i(clear),
        .push_i(tdo_push), .din_i(tdo_byte), .pop_i(tdo_pop),
        .dout_o(tdo_head), .empty_o(tdo_empty), .full_o(tdo_full)
    );

    jtg_shifter #(.HALF_DIV(HALF_DIV), .IDLE_TMS(IDLE_TMS), .IDLE_TDI(IDLE_TDI)) u_shift (
        .clk          (clk),
        .rst          (rst),
        .run_i        (run),
        .flush_i      (clear),
        .pair_avail_i (pair_avail),
        .pair_i       (pair),
        .tdo_full_i   (tdo_full),
        .tdo_i        (tdo_i),
        .pair_pop_o   (pair_pop),
        .tdo_push_o   (tdo_push),
        .tdo_byte_o   (tdo_byte),
        .active_o     (active),
        .tck_o        (tck_o),
        .tms_o        (tms_o),
        .tdi_o        (tdi_o)
    );

    AST_PAIR_POP_BOTH: assert property (@(posedge clk) disable iff (rst)
        pair_pop |-> (!tms_empty && !tdi_empty)) // R4
        else $error("byte pair taken with an empty queue");

    AST_FULL_DROP_TMS: assert property (@(posedge clk) disable iff (rst)
        (tms_push && tms_full && !pair_pop && !clear) |=> tms_full) // R2
        else $error("mode-select queue left full state on dropped write");

    AST_FULL_DROP_TDI: assert property (@(posedge clk) disable iff (rst)
        (tdi_push && tdi_full && !pair_pop && !clear) |=> tdi_full) // R2
        else $error("data-in queue left full state on dropped write");

endmodule

// File: tb/sim_jtg_byte_engine.sv
module sim_jtg_byte_engine;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int DEPTH      = 16;
    localparam int LOGN       = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] rdata;
    logic       tck, tms, tdi;
    logic       tdo = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jtg_byte_engine #(.FIFO_DEPTH(DEPTH), .HALF_DIV(HALF)) u0 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata),
        .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata),
        .tck_o(tck), .tms_o(tms), .tdi_o(tdi), .tdo_i(tdo)
    );

    int   n_chk = 0, n_fail = 0;
    int   rcnt = 0;
    bit   log_en = 1'b0;
    logic tms_log [LOGN];
    logic tdi_log [LOGN];
    logic tdo_log [LOGN];

    function automatic logic tdo_bit(input int k);
        return (((k * 13 + 5) >> 2) & 1) != 0;
    endfunction

    always @(posedge tck) begin
        if (log_en && rcnt < LOGN) begin
            tms_log[rcnt] = tms;
            tdi_log[rcnt] = tdi;
            tdo_log[rcnt] = tdo;
            rcnt++;
        end
    end

    always @(negedge tck) tdo = tdo_bit(rcnt);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1;
        d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 4000; i++) begin
            bus_read(3'd3, s);
            if (!s[0]) break;
        end
    endtask

    task automatic log_start();
        @(negedge clk);
        rcnt = 0;
        log_en = 1'b1;
    endtask

    function automatic logic [7:0] tms_byte(input int base);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[i] = tms_log[base + i];
        return b;
    endfunction

    function automatic logic [7:0] tdi_byte(input int base);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[i] = tdi_log[base + i];
        return b;
    endfunction

    function automatic logic [7:0] tdo_byte(input int base);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[i] = tdo_log[base + i];
        return b;
    endfunction

    task automatic t_reset_state();
        logic [7:0] s;
        chk(tck == 1'b0, "R1 tck after reset", int'(tck), 0);
        chk(tms == 1'b0 && tdi == 1'b0, "R1 tms/tdi after reset", int'({tms, tdi}), 0);
        bus_read(3'd3, s);
        chk(s == 8'h00, "R1 R10 status after reset", int'(s), 0);
    endtask

    task automatic t_no_go();
        logic [7:0] s;
        bus_write(3'd2, 8'h02);
        log_start();
        bus_write(3'd0, 8'hA5);
        bus_write(3'd1, 8'h3C);
        bus_write(3'd0, 8'h0F);
        bus_write(3'd1, 8'h81);
        repeat (40) @(negedge clk);
        chk(rcnt == 0, "R3 no tck before start", rcnt, 0);
        bus_read(3'd3, s);
        chk(s == 8'h01, "R10 busy with pair waiting", int'(s), 1);
    endtask

    task automatic t_shift();
        bus_write(3'd2, 8'h00);
        wait_idle();
        chk(rcnt >= 16, "R4 data bits clocked", rcnt, 16);
        chk(tms_byte(0) == 8'h3C, "R4 tms byte0 lsb first", int'(tms_byte(0)), 'h3C);
        chk(tdi_byte(0) == 8'hA5, "R4 tdi byte0 lsb first", int'(tdi_byte(0)), 'hA5);
        chk(tms_byte(8) == 8'h81, "R4 tms byte1", int'(tms_byte(8)), 'h81);
        chk(tdi_byte(8) == 8'h0F, "R4 tdi byte1", int'(tdi_byte(8)), 'h0F);
    endtask

    task automatic t_idle_repeat();
        int bad = 0;
        int start = rcnt;
        repeat (40) @(negedge clk);
        chk(rcnt > start + 4, "R5 tck keeps running when idle", rcnt, start + 5);
        for (int i = 16; i < rcnt; i++)
            if (tms_log[i] !== 1'b1 || tdi_log[i] !== 1'b0) bad++;
        chk(bad == 0, "R5 pins hold last bit", bad, 0);
    endtask

    task automatic t_tdo_lag();
        logic [7:0] s, d;
        bus_read(3'd3, s);
        chk(s == 8'h02, "R6 R10 one packed byte ready", int'(s), 2);
        bus_read(3'd4, d);
        chk(d == tdo_byte(0), "R6 first captured byte", int'(d), int'(tdo_byte(0)));
        bus_read(3'd3, s);
        chk(s[1] == 1'b0, "R6 second byte held until flush", int'(s), 0);
        bus_write(3'd0, 8'h00);
        bus_write(3'd1, 8'h00);
        wait_idle();
        bus_read(3'd4, d);
        chk(d == tdo_byte(8), "R6 flushed second byte", int'(d), int'(tdo_byte(8)));
        bus_read(3'd3, s);
        chk(s[1] == 1'b0, "R6 read queue empty after pop", int'(s), 0);
    endtask

    task automatic t_pace();
        int nh = 0, nl = 0;
        @(posedge tck);
        @(negedge clk);
        while (tck) begin nh++; @(negedge clk); end
        while (!tck) begin nl++; @(negedge clk); end
        chk(nh == HALF, "R8 tck high phase", nh, HALF);
        chk(nl == HALF, "R8 tck idle low phase", nl, HALF);
    endtask

    task automatic t_stop();
        int hi = 0;
        int r0;
        bus_write(3'd2, 8'h01);
        @(negedge clk);
        r0 = rcnt;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (tck) hi++;
        end
        chk(hi == 0, "R7 tck low after stop", hi, 0);
        chk(rcnt == r0, "R7 no edges after stop", rcnt, r0);
    endtask

    task automatic t_pairing();
        logic [7:0] s;
        int bad = 0;
        bus_write(3'd2, 8'h02);
        log_start();
        bus_write(3'd1, 8'hFF);
        bus_write(3'd1, 8'hFF);
        bus_write(3'd1, 8'hFF);
        bus_read(3'd3, s);
        chk(s == 8'h00, "R10 not busy without a full pair", int'(s), 0);
        bus_write(3'd2, 8'h00);
        repeat (40) @(negedge clk);
        for (int i = 0; i < rcnt; i++) if (tms_log[i] !== 1'b0) bad++;
        chk(rcnt > 0 && bad == 0, "R4 lone mode-select bytes not shifted", bad, 0);
        bus_write(3'd2, 8'h01);
    endtask

    task automatic t_overflow();
        int bad = 0;
        bus_write(3'd2, 8'h02);
        log_start();
        for (int i = 0; i < DEPTH; i++) begin
            bus_write(3'd0, 8'h00);
            bus_write(3'd1, 8'h00);
        end
        bus_write(3'd0, 8'hFF);
        bus_write(3'd1, 8'hFF);
        bus_write(3'd2, 8'h00);
        wait_idle();
        repeat (30) @(negedge clk);
        chk(rcnt >= 8 * DEPTH, "R2 all queued bytes shifted", rcnt, 8 * DEPTH);
        for (int i = 0; i < rcnt; i++) if (tms_log[i] !== 1'b0 || tdi_log[i] !== 1'b0) bad++;
        chk(bad == 0, "R2 byte written to full queue dropped", bad, 0);
    endtask

    task automatic t_clear();
        logic [7:0] s;
        int bad = 0;
        bus_write(3'd2, 8'h01);
        bus_write(3'd0, 8'hFF);
        bus_write(3'd1, 8'hFF);
        bus_read(3'd3, s);
        chk(s == 8'h03, "R10 busy and data ready before clear", int'(s), 3);
        bus_write(3'd2, 8'h02);
        bus_read(3'd3, s);
        chk(s == 8'h00, "R9 queues empty after clear", int'(s), 0);
        chk(tck == 1'b0 && tms == 1'b0 && tdi == 1'b0, "R9 pins idle after clear", int'({tck, tms, tdi}), 0);
        log_start();
        bus_write(3'd2, 8'h00);
        repeat (40) @(negedge clk);
        for (int i = 0; i < rcnt; i++) if (tms_log[i] !== 1'b0 || tdi_log[i] !== 1'b0) bad++;
        chk(bad == 0, "R9 discarded pair never shifted", bad, 0);
        bus_read(3'd3, s);
        chk(s == 8'h00, "R9 held packer byte discarded", int'(s), 0);
        bus_write(3'd2, 8'h01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_no_go();
        t_shift();
        t_idle_repeat();
        t_tdo_lag();
        t_pace();
        t_stop();
        t_pairing();
        t_overflow();
        t_clear();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule